// File: doc/BRIEF.md
# Serial Divider-Ratio Loader

This block takes a three-wire serial stream (shift clock, data, latch enable) from a slow controller and turns it into two parallel ratio words for a pair of frequency dividers: a 16-bit main-loop ratio and a narrower reference ratio. All three serial wires are asynchronous to the system clock. They pass through a synchronizer, and then through edge detection, before any state changes.

A programming word has 17 bits. The 16 ratio bits come first, most significant bit first, and one steering bit follows them. Bits enter a 17-bit shift register on each rising edge of the shift clock. When latch enable rises, the steering bit chooses which holding register takes the word. For the reference register, the two lowest ratio bits are always discarded. In the narrow variant (parameter `NARROW=1`) the three highest bits are discarded as well, which leaves 11 bits instead of 14. A one-cycle strobe reports each update, so the divider it feeds can reload.

Top module: `serial_ratio_loader`

## Requirements
- R1: While `rst` is high, and after it falls, `main_ratio` reads 1056, `ref_ratio` reads 20 and both strobes are low, until the first transfer.
- R2: A bit is captured only on a rising edge of `ser_clk`. Of the last 17 captured bits, the first 16 form the ratio word, first-sent bit as bit 15, and the 17th is the steering bit.
- R3: A transfer with steering bit 0 writes all 16 ratio bits into `main_ratio`.
- R4: In the wide variant (`NARROW=0`), a transfer with steering bit 1 writes ratio bits 15..2 into `ref_ratio` (14 bits) and drops bits 1..0.
- R5: In the narrow variant (`NARROW=1`), a transfer with steering bit 1 writes ratio bits 12..2 into `ref_ratio` (11 bits) and drops bits 15..13 and 1..0.
- R6: The register the steering bit does not select keeps its previous value across a transfer.
- R7: A transfer happens once per rising edge of `ser_le`. Holding `ser_le` high produces no further updates.
- R8: Rising edges of `ser_clk` while `ser_le` is high shift nothing into the register.
- R9: Each transfer raises exactly one of `main_upd` / `ref_upd` for exactly one system clock cycle, matching the steering bit. The two strobes are never high together.
- R10: `main_ratio` changes only in a cycle where `main_upd` is high, and `ref_ratio` changes only in a cycle where `ref_upd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, stable around rising `ser_clk` |
| ser_le | input | 1 | Latch enable; a rising edge transfers the word |
| main_ratio | output | 16 | Main divider ratio |
| ref_ratio | output | 14 (11 if NARROW=1) | Reference divider ratio |
| main_upd | output | 1 | One-cycle pulse when `main_ratio` is written |
| ref_upd | output | 1 | One-cycle pulse when `ref_ratio` is written |

## Verification
A shift register that is off by one bit shows up in the ratio word a few system clocks after the next rising edge of latch enable. It appears as a value halved or doubled, or as the steering decision flipped so that the wrong register changes. Errors in the edge detector or the enable gating show up as extra or missing strobe pulses, seen within three cycles of a latch-enable edge. Writes during latch-enable high that are not ignored reach the ports on the next re-latch. The bench runs a wide and a narrow instance side by side on the same stream. A wrong field slice is therefore seen as a difference between the two `ref_ratio` values on the same transfer.

// File: rtl/srl_pkg.sv
package srl_pkg;
   // Steering bit value: selects the destination holding register
   typedef enum logic {
      DEST_MAIN = 1'b0,
      DEST_REF  = 1'b1
   } dest_e;

   // Reference field width from ratio width and discarded bit counts
   function automatic int ref_width(input int data_w, input int lo, input int hi);
      return data_w - lo - hi;
   endfunction
endpackage

// File: rtl/srl_sync.sv
module srl_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("srl_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (rst) chain <= '0;
         else     chain <= {chain[STAGES-2:0], async_in[b]};
      end
      assign sync_out[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/srl_shifter.sv
module srl_shifter #(
   parameter int LEN = 17
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           shift_en,
   input  logic           bit_in,
   output logic [LEN-1:0] word
);
   if (LEN < 2) begin : g_bad_len
      $error("srl_shifter: LEN must be at least 2");
   end

   // Bits move toward the MSB, so the first bit received ends up on top
   always_ff @(posedge clk) begin
      if (rst)           word <= '0;
      else if (shift_en) word <= {word[LEN-2:0], bit_in};
   end
endmodule

// File: rtl/srl_latch_bank.sv
module srl_latch_bank
   import srl_pkg::*;
#(
   parameter int              DATA_W  = 16,
   parameter int              DROP_LO = 2,
   parameter int              DROP_HI = 0,
   parameter logic [DATA_W-1:0] N_RESET = 16'd1056,
   parameter int              R_RESET = 20,
   localparam int             R_W     = ref_width(DATA_W, DROP_LO, DROP_HI)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W:0]   word,
   output logic [DATA_W-1:0] main_ratio,
   output logic [R_W-1:0]    ref_ratio,
   output logic              main_upd,
   output logic              ref_upd
);
   if (R_W < 1) begin : g_bad_rw
      $error("srl_latch_bank: discarded bits leave no reference field");
   end

   logic [DATA_W-1:0] ratio_bits;
   dest_e             dest;
   logic [R_W-1:0]    ref_field;

   assign ratio_bits = word[DATA_W:1];
   assign dest       = dest_e'(word[0]);

   if (DROP_HI == 0) begin : g_wide
      assign ref_field = ratio_bits[DATA_W-1:DROP_LO];
   end else begin : g_narrow
      assign ref_field = ratio_bits[DATA_W-1-DROP_HI:DROP_LO];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         main_ratio <= N_RESET;
         ref_ratio  <= R_W'(R_RESET);
         main_upd   <= 1'b0;
         ref_upd    <= 1'b0;
      end else begin
         main_upd <= load && (dest == DEST_MAIN);
         ref_upd  <= load && (dest == DEST_REF);
         if (load && dest == DEST_MAIN) main_ratio <= ratio_bits;
         if (load && dest == DEST_REF)  ref_ratio  <= ref_field;
      end
   end
endmodule

// File: rtl/serial_ratio_loader.sv
module serial_ratio_loader #(
   parameter int                N_W         = 16,
   parameter bit                NARROW      = 1'b0,
   parameter int                SYNC_STAGES = 2,
   parameter logic [N_W-1:0]    N_RESET     = 16'd1056,
   parameter int                R_RESET     = 20,
   localparam int               DROP_LO     = 2,
   localparam int               DROP_HI     = NARROW ? 3 : 0,
   localparam int               R_W         = N_W - DROP_LO - DROP_HI,
   localparam int               WORD_LEN    = N_W + 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           ser_clk,
   input  logic           ser_data,
   input  logic           ser_le,
   output logic [N_W-1:0] main_ratio,
   output logic [R_W-1:0] ref_ratio,
   output logic           main_upd,
   output logic           ref_upd
);
   if (N_W < 8) begin : g_bad_nw
      $error("serial_ratio_loader: N_W too small");
   end
   if (R_RESET >= (1 << R_W)) begin : g_bad_rreset
      $error("serial_ratio_loader: R_RESET does not fit the reference field");
   end

   logic [2:0]          sync_lvl;
   logic                sclk_prev, le_prev;
   logic                sclk_rise, le_rise;
   logic [WORD_LEN-1:0] shreg;

   srl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in ({ser_le, ser_data, ser_clk}),
      .sync_out (sync_lvl)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_prev <= 1'b0;
         le_prev   <= 1'b0;
      end else begin
         sclk_prev <= sync_lvl[0];
         le_prev   <= sync_lvl[2];
      end
   end

   assign sclk_rise = sync_lvl[0] & ~sclk_prev;
   assign le_rise   = sync_lvl[2] & ~le_prev;

   srl_shifter #(.LEN(WORD_LEN)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .shift_en (sclk_rise & ~sync_lvl[2]),
      .bit_in   (sync_lvl[1]),
      .word     (shreg)
   );

   srl_latch_bank #(
      .DATA_W  (N_W),
      .DROP_LO (DROP_LO),
      .DROP_HI (DROP_HI),
      .N_RESET (N_RESET),
      .R_RESET (R_RESET)
   ) u_bank (
      .clk        (clk),
      .rst        (rst),
      .load       (le_rise),
      .word       (shreg),
      .main_ratio (main_ratio),
      .ref_ratio  (ref_ratio),
      .main_upd   (main_upd),
      .ref_upd    (ref_upd)
   );
endmodule

// File: rtl/srl_checker.sv
module srl_checker #(
   parameter int             N_W     = 16,
   parameter int             R_W     = 14,
   parameter logic [N_W-1:0] N_RESET = 16'd1056,
   parameter int             R_RESET = 20
) (
   input logic           clk,
   input logic           rst,
   input logic [N_W-1:0] main_ratio,
   input logic [R_W-1:0] ref_ratio,
   input logic           main_upd,
   input logic           ref_upd
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (main_ratio == N_RESET && ref_ratio == R_W'(R_RESET) && !main_upd && !ref_upd));

   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(main_upd && ref_upd));

   // R9
   main_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      main_upd |=> !main_upd);

   // R9
   ref_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ref_upd |=> !ref_upd);

   // R10
   main_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !main_upd |-> $stable(main_ratio));

   // R10
   ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ref_upd |-> $stable(ref_ratio));
endmodule

bind serial_ratio_loader srl_checker #(
   .N_W(N_W), .R_W(R_W), .N_RESET(N_RESET), .R_RESET(R_RESET)
) u_chk (
   .clk(clk), .rst(rst), .main_ratio(main_ratio), .ref_ratio(ref_ratio),
   .main_upd(main_upd), .ref_upd(ref_upd)
);

// File: tb/tb_serial_ratio_loader.sv
module tb_serial_ratio_loader;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_BIT   = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
   logic [15:0] main_w, main_n;
   logic [13:0] ref_w;
   logic [10:0] ref_n;
   logic        mu_w, ru_w, mu_n, ru_n;

   int errors = 0, checks = 0;
   int cnt_main = 0, cnt_ref = 0;
   bit done = 1'b0;

   logic [15:0] exp_main = 16'd1056;
   logic [13:0] exp_ref_w = 14'd20;
   logic [10:0] exp_ref_n = 11'd20;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_ratio_loader #(.NARROW(1'b0)) dut (
      .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
      .main_ratio(main_w), .ref_ratio(ref_w), .main_upd(mu_w), .ref_upd(ru_w));

   serial_ratio_loader #(.NARROW(1'b1)) dut_narrow (
      .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
      .main_ratio(main_n), .ref_ratio(ref_n), .main_upd(mu_n), .ref_upd(ru_n));

   always @(negedge clk) begin
      if (!rst) begin
         if (mu_w) cnt_main++;
         if (ru_w) cnt_ref++;
      end
   end

   // {ratio word, steering bit}
   localparam logic [16:0] VEC [8] = '{
      {16'hA5C3, 1'b0}, {16'hFFFF, 1'b1}, {16'h1234, 1'b1}, {16'h0420, 1'b0},
      {16'hFFFF, 1'b0}, {16'h8003, 1'b1}, {16'h0000, 1'b1}, {16'h7FFC, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic shift_bit(input logic b);
      ser_data = b;
      wait_clk(HALF_BIT);
      ser_clk = 1'b1;
      wait_clk(HALF_BIT);
      ser_clk = 1'b0;
   endtask

   task automatic pulse_le;
      wait_clk(HALF_BIT);
      ser_le = 1'b1;
      wait_clk(8);
      ser_le = 1'b0;
      wait_clk(HALF_BIT);
   endtask

   task automatic send_word(input logic [15:0] w, input logic ctl);
      for (int i = 15; i >= 0; i--) shift_bit(w[i]);
      shift_bit(ctl);
      pulse_le();
   endtask

   task automatic check_all(input string tag);
      @(negedge clk);
      chk({tag, " main wide"}, 32'(main_w), 32'(exp_main));
      chk({tag, " main narrow"}, 32'(main_n), 32'(exp_main));
      chk({tag, " ref wide"}, 32'(ref_w), 32'(exp_ref_w));
      chk({tag, " ref narrow"}, 32'(ref_n), 32'(exp_ref_n));
   endtask

   initial begin
      int m0, r0;
      wait_clk(5);
      @(negedge clk);
      // R1: values during reset
      chk("R1 main in reset", 32'(main_w), 32'd1056);
      chk("R1 ref in reset", 32'(ref_w), 32'd20);
      rst = 1'b0;
      wait_clk(3);
      check_all("R1 after reset");
      chk("R1 strobes idle", 32'({mu_w, ru_w}), 32'd0);

      // R2 R3 R4 R5 R6 R9: table-driven transfers
      for (int v = 0; v < 8; v++) begin
         m0 = cnt_main; r0 = cnt_ref;
         send_word(VEC[v][16:1], VEC[v][0]);
         if (VEC[v][0] == 1'b0) begin
            exp_main = VEC[v][16:1];
         end else begin
            exp_ref_w = VEC[v][16:3];
            exp_ref_n = VEC[v][13:3];
         end
         check_all($sformatf("R2/R3/R4/R5/R6 vec%0d", v));
         chk($sformatf("R9 main strobes vec%0d", v), 32'(cnt_main - m0), 32'(VEC[v][0] ? 0 : 1));
         chk($sformatf("R9 ref strobes vec%0d", v), 32'(cnt_ref - r0), 32'(VEC[v][0] ? 1 : 0));
      end

      // R7: latch enable held high a long time gives one update
      m0 = cnt_main;
      for (int i = 15; i >= 0; i--) shift_bit(~exp_main[i]);
      shift_bit(1'b0);
      ser_le = 1'b1;
      wait_clk(200);
      exp_main = ~exp_main;
      check_all("R7 long LE");
      chk("R7 single strobe", 32'(cnt_main - m0), 32'd1);

      // R8: shift clocks while LE high are ignored; re-latch gives same word
      for (int i = 0; i < 6; i++) shift_bit(1'b1);
      ser_le = 1'b0;
      wait_clk(8);
      m0 = cnt_main;
      pulse_le();
      check_all("R8 clocks during LE high");
      chk("R8 re-latch strobe", 32'(cnt_main - m0), 32'd1);

      // R6 corner: ref write leaves main unchanged at extreme values
      send_word(16'h0003, 1'b1);
      exp_ref_w = 14'd0; exp_ref_n = 11'd0;
      check_all("R6 ref zero");

      // R1: reset mid-operation restores defaults
      rst = 1'b1;
      wait_clk(3);
      rst = 1'b0;
      exp_main = 16'd1056; exp_ref_w = 14'd20; exp_ref_n = 11'd20;
      wait_clk(2);
      check_all("R1 re-reset");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait_clk(200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule